// File: doc/BRIEF.md
# DMA Channel Request Gating and Mode Registers

This block holds the per-channel gating and mode state for a four-channel DMA engine. A processor-side port performs strobed byte writes and reads through a 4-bit address. Writes can change four mask bits, four software request bits and four 6-bit mode words. The block combines each channel's hardware request line with its mask bit and its software request bit. From these it produces a registered effective request vector for a downstream arbiter. It also exposes every channel's stored mode as decoded fields.

A channel that finishes its transfer pulses its end-of-process input. Unless that channel is set to auto-initialize, its mask bit then sets itself, and the channel stays quiet until software clears the bit again. Software requests ignore the mask. Readback fills the bits that carry no state with ones.

Every processor write is classified into one command kind, using the address and the write strobe: NONE (no strobe or an unmapped address), MASK_ONE, MASK_ALL, MASK_CLR, MCLR, REQ or MODE. Each register's update is one case over these kinds. No other sequencing exists, and every kind returns to NONE on the next cycle when the strobe drops.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset, all four mask bits are 1, all software request bits are 0, all mode words are 0, `eff_req` is 0 and `rdata` is 0.
- R2: A write to address 0 (MASK_ONE) writes data bit 2 into the mask bit of the channel selected by data bits 1:0. Data bits 7:3 are ignored.
- R3: A write to address 1 (MASK_ALL) loads data bits 3:0 into the mask bits of channels 0 to 3.
- R4: A write to address 2 (MASK_CLR) clears all four mask bits, whatever the data value.
- R5: A write to address 3 (MCLR) sets all four mask bits and clears all software request bits. It leaves the mode words unchanged.
- R6: A write to address 4 (REQ) writes data bit 2 into the software request bit of the channel selected by data bits 1:0.
- R7: A write to any address 8 to 11 (MODE) stores data bits 7:2 as the mode word of the channel selected by data bits 1:0. The word is decoded as follows:
  - type = bits 3:2 (00 verify, 01 write, 10 read), on `xfer_type[2c+1:2c]`;
  - auto-initialize = bit 4, on `auto_init[c]`;
  - address decrement = bit 5, on `addr_dec[c]`;
  - mode = bits 7:6 (00 demand, 01 single, 10 block, 11 cascade), on `xfer_mode[2c+1:2c]`.
- R8: On the clock edge where `rd_en` is high, `rdata` loads one of the following, and otherwise it holds its value:
  - address 0 returns {4'hF, mask};
  - address 4 returns {4'hF, requests};
  - address 8+c returns {mode word c, 2'b11};
  - any other address returns 8'hFF.
- R9: An `eop[c]` pulse sets mask bit c when the channel's auto-initialize bit is 0, and leaves the bit unchanged when it is 1.
- R10: When an end-of-process set and a software clear (MASK_ONE, MASK_ALL or MASK_CLR) hit the same mask bit in the same cycle, the bit ends up set.
- R11: `eff_req` is registered and equals (dreq AND NOT mask) OR requests, taken from the register values before the edge. A software request drives `eff_req` even while its mask bit is set.
- R12: A write changes its register at the clock edge where `wr_en` is high. Its effect on `eff_req` therefore appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| dreq | input | 4 | Hardware request per channel |
| eop | input | 4 | End-of-process pulse per channel |
| eff_req | output | 4 | Registered effective request per channel |
| xfer_type | output | 8 | Transfer type, 2 bits per channel |
| auto_init | output | 4 | Auto-initialize enable per channel |
| addr_dec | output | 4 | Address decrement select per channel |
| xfer_mode | output | 8 | Transfer mode, 2 bits per channel |

## Verification
Register writes and end-of-process pulses change state at the edge that samples them, so the bench checks their effect by a read one cycle later. Read data is valid after the edge that sees `rd_en`, and the bench compares it at the following falling edge. The effective request lags the register state by one more edge, so the bench checks `eff_req` twice after a mask change: once at the falling edge right after the write, when it must still show the old value, and once a cycle later, when it must show the new one. The decoded mode fields are combinational from the stored words and are compared after the write edge.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    localparam int NCH   = 4;               // channels
    localparam int DW    = 8;               // data bus width
    localparam int AW    = 4;               // address width
    localparam int CW    = $clog2(NCH);     // channel select width
    localparam int MW    = DW - CW;         // stored mode word width
    localparam int FILLW = DW - NCH;        // readback fill width

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MASK_ONE,
        CMD_MASK_ALL,
        CMD_MASK_CLR,
        CMD_MCLR,
        CMD_REQ,
        CMD_MODE
    } cmd_e;

    typedef struct packed {
        logic [1:0] tmode;   // 00 demand, 01 single, 10 block, 11 cascade
        logic       dec;     // address decrement
        logic       autoi;   // auto-initialize
        logic [1:0] ttype;   // 00 verify, 01 write, 10 read
    } mode_t;

endpackage

// File: rtl/dmarq_cmd_decode.sv
module dmarq_cmd_decode
    import dmarq_pkg::*;
(
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output cmd_e          cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (wr_en) begin
            unique casez (addr)
                4'b0000: cmd = CMD_MASK_ONE;
                4'b0001: cmd = CMD_MASK_ALL;
                4'b0010: cmd = CMD_MASK_CLR;
                4'b0011: cmd = CMD_MCLR;
                4'b0100: cmd = CMD_REQ;
                4'b10??: cmd = CMD_MODE;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dmarq_mask_reg.sv
module dmarq_mask_reg
    import dmarq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  cmd_e           cmd,
    input  logic [NCH-1:0] wbits,    // data bits 3:0
    input  logic [NCH-1:0] eop,
    input  logic [NCH-1:0] autoi,
    output logic [NCH-1:0] mask
);

    logic [NCH-1:0] sw_next;
    logic [NCH-1:0] eop_set;

    assign eop_set = eop & ~autoi;

    always_comb begin
        sw_next = mask;
        unique case (cmd)
            CMD_MASK_ONE: sw_next[wbits[CW-1:0]] = wbits[CW];
            CMD_MASK_ALL: sw_next = wbits;
            CMD_MASK_CLR: sw_next = '0;
            CMD_MCLR:     sw_next = '1;
            default:      sw_next = mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mask <= '1;
        else     mask <= sw_next | eop_set;   // end-of-process wins
    end

    assert_eop_sets_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((mask & $past(eop & ~autoi)) == $past(eop & ~autoi)));

    assert_clear_all_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MASK_CLR && eop == '0) |=> (mask == '0));

    assert_mclr_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MCLR) |=> (mask == '1));

endmodule

// File: rtl/dmarq_req_reg.sv
module dmarq_req_reg
    import dmarq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  cmd_e           cmd,
    input  logic [CW:0]    wbits,    // data bits 2:0
    output logic [NCH-1:0] req
);

    logic [NCH-1:0] req_next;

    always_comb begin
        req_next = req;
        unique case (cmd)
            CMD_REQ:  req_next[wbits[CW-1:0]] = wbits[CW];
            CMD_MCLR: req_next = '0;
            default:  req_next = req;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) req <= '0;
        else     req <= req_next;
    end

    assert_mclr_req_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MCLR) |=> (req == '0));

    assert_req_set_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REQ && wbits[CW]) |=> ($countones(req) >= 1));

endmodule

// File: rtl/dmarq_mode_bank.sv
module dmarq_mode_bank
    import dmarq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [DW-1:0]     wdata,
    output mode_t [NCH-1:0]   mode
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                mode[c] <= '0;
            else if (cmd == CMD_MODE && wdata[CW-1:0] == CW'(c))
                mode[c] <= mode_t'(wdata[DW-1:CW]);
        end

        assert_mode_store_R7: assert property (@(posedge clk) disable iff (rst)
            (cmd == CMD_MODE && wdata[CW-1:0] == CW'(c))
            |=> (mode[c] == $past(wdata[DW-1:CW])));
    end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dmarq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [3:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [3:0]   dreq,
    input  logic [3:0]   eop,
    output logic [3:0]   eff_req,
    output logic [7:0]   xfer_type,
    output logic [3:0]   auto_init,
    output logic [3:0]   addr_dec,
    output logic [7:0]   xfer_mode
);

    cmd_e            cmd;
    logic [NCH-1:0]  mask;
    logic [NCH-1:0]  sw_req;
    mode_t [NCH-1:0] mode;
    logic [DW-1:0]   rd_next;

    dmarq_cmd_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .cmd   (cmd)
    );

    dmarq_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wbits (wdata[NCH-1:0]),
        .eop   (eop),
        .autoi (auto_init),
        .mask  (mask)
    );

    dmarq_req_reg u_req (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wbits (wdata[CW:0]),
        .req   (sw_req)
    );

    dmarq_mode_bank u_mode (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wdata (wdata),
        .mode  (mode)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_fields
        assign xfer_type[2*c +: 2] = mode[c].ttype;
        assign xfer_mode[2*c +: 2] = mode[c].tmode;
        assign auto_init[c]        = mode[c].autoi;
        assign addr_dec[c]         = mode[c].dec;
    end

    always_comb begin
        unique casez (addr)
            4'b0000: rd_next = {{FILLW{1'b1}}, mask};
            4'b0100: rd_next = {{FILLW{1'b1}}, sw_req};
            4'b10??: rd_next = {mode[addr[CW-1:0]], {CW{1'b1}}};
            default: rd_next = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            eff_req <= '0;
        end else begin
            if (rd_en) rdata <= rd_next;
            eff_req <= (dreq & ~mask) | sw_req;
        end
    end

    assert_sw_bypass_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((eff_req & $past(sw_req)) == $past(sw_req)));

    assert_mask_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((eff_req & $past(mask & ~sw_req)) == '0));

    assert_mask_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 4'h0) |=> (rdata[7:4] == 4'hF));

    assert_mode_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[3:2] == 2'b10) |=> (rdata[1:0] == 2'b11));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/dma_req_ctrl_bench.sv
module dma_req_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [3:0] dreq, eop;
    logic [3:0] eff_req;
    logic [7:0] xfer_type, xfer_mode;
    logic [3:0] auto_init, addr_dec;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dma_req_ctrl u_dma_req_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dreq(dreq), .eop(eop),
        .eff_req(eff_req), .xfer_type(xfer_type), .auto_init(auto_init),
        .addr_dec(addr_dec), .xfer_mode(xfer_mode)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 30;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {1'b0, 4'h0, 8'h00, 8'hFF},  // R1 mask after reset
        {1'b0, 4'h4, 8'h00, 8'hF0},  // R1 requests after reset
        {1'b0, 4'h9, 8'h00, 8'h03},  // R1 mode after reset
        {1'b1, 4'h2, 8'h5A, 8'h00},  // R4 clear all, data ignored
        {1'b0, 4'h0, 8'h00, 8'hF0},  // R4
        {1'b1, 4'h0, 8'h05, 8'h00},  // R2 set ch1
        {1'b0, 4'h0, 8'h00, 8'hF2},  // R2
        {1'b1, 4'h0, 8'hF9, 8'h00},  // R2 clear ch1, upper bits ignored
        {1'b0, 4'h0, 8'h00, 8'hF0},  // R2
        {1'b1, 4'h0, 8'hFE, 8'h00},  // R2 set ch2
        {1'b0, 4'h0, 8'h00, 8'hF4},  // R2
        {1'b1, 4'h1, 8'hAA, 8'h00},  // R3 write all
        {1'b0, 4'h0, 8'h00, 8'hFA},  // R3
        {1'b1, 4'h4, 8'h06, 8'h00},  // R6 set ch2
        {1'b1, 4'h4, 8'h07, 8'h00},  // R6 set ch3
        {1'b0, 4'h4, 8'h00, 8'hFC},  // R6
        {1'b1, 4'h4, 8'h02, 8'h00},  // R6 reset ch2
        {1'b0, 4'h4, 8'h00, 8'hF8},  // R6
        {1'b1, 4'h8, 8'h99, 8'h00},  // R7 ch1 block autoinit read
        {1'b0, 4'h9, 8'h00, 8'h9B},  // R7
        {1'b0, 4'h8, 8'h00, 8'h03},  // R7 ch0 untouched
        {1'b1, 4'hB, 8'h4E, 8'h00},  // R7 ch2 via address 11
        {1'b0, 4'hA, 8'h00, 8'h4F},  // R7
        {1'b1, 4'h8, 8'hE3, 8'h00},  // R7 ch3 cascade decrement
        {1'b0, 4'hB, 8'h00, 8'hE3},  // R7
        {1'b0, 4'h5, 8'h00, 8'hFF},  // R8 unmapped
        {1'b1, 4'h3, 8'h00, 8'h00},  // R5 master clear
        {1'b0, 4'h0, 8'h00, 8'hFF},  // R5
        {1'b0, 4'h4, 8'h00, 8'hF0},  // R5
        {1'b0, 4'h9, 8'h00, 8'h9B}   // R5 modes kept
    };
    localparam int VREQ [0:NV-1] = '{1,1,1,4,4,2,2,2,2,2,2,3,3,6,6,6,6,6,
                                     7,7,7,7,7,7,7,8,5,5,5,5};

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        dreq = '0; eop = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdata", rdata, 8'h00);
        check("R1 eff_req", {4'h0, eff_req}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                do_write(VEC[i][19:16], VEC[i][15:8]);
            end else begin
                do_read(VEC[i][19:16], v);
                check($sformatf("R%0d vector %0d", VREQ[i], i), v, VEC[i][7:0]);
            end
        end

        // R7 decoded fields
        check("R7 xfer_mode", xfer_mode, 8'hD8);
        check("R7 xfer_type", xfer_type, 8'h38);
        check("R7 auto_init", {4'h0, auto_init}, 8'h02);
        check("R7 addr_dec", {4'h0, addr_dec}, 8'h08);

        // R11 / R12 mask gating with registered output
        dreq = 4'hF;
        @(negedge clk); @(negedge clk);
        check("R11 masked dreq", {4'h0, eff_req}, 8'h00);
        do_write(4'h2, 8'h00);
        check("R12 eff_req lags write", {4'h0, eff_req}, 8'h00);
        @(negedge clk);
        check("R11 unmasked dreq", {4'h0, eff_req}, 8'h0F);

        // R11 software request bypasses mask
        dreq = 4'h0;
        do_write(4'h1, 8'h0F);
        do_write(4'h4, 8'h06);
        @(negedge clk);
        check("R11 sw bypass", {4'h0, eff_req}, 8'h04);
        do_write(4'h4, 8'h02);

        // R9 end of process: ch0 no autoinit, ch1 autoinit
        do_write(4'h2, 8'h00);
        @(negedge clk);
        eop = 4'b0011;
        @(negedge clk);
        eop = 4'b0000;
        do_read(4'h0, v);
        check("R9 eop masking", v, 8'hF1);

        // R10 eop vs single clear on ch2
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h0; wdata = 8'h02; eop = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; eop = 4'b0000;
        do_read(4'h0, v);
        check("R10 eop beats single clear", v, 8'hF5);

        // R10 eop vs clear-all on ch3
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h2; wdata = 8'h00; eop = 4'b1000;
        @(negedge clk);
        wr_en = 1'b0; eop = 4'b0000;
        do_read(4'h0, v);
        check("R10 eop beats clear all", v, 8'hF8);

        // R1 reset mid-run
        do_write(4'h2, 8'h00);
        do_write(4'h4, 8'h04);
        dreq = 4'hF;
        @(negedge clk); @(negedge clk);
        check("R11 before reset", {4'h0, eff_req}, 8'h0F);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 rdata cleared", rdata, 8'h00);
        check("R1 eff_req cleared", {4'h0, eff_req}, 8'h00);
        check("R1 auto_init cleared", {4'h0, auto_init}, 8'h00);
        @(negedge clk);
        check("R1 masked after reset", {4'h0, eff_req}, 8'h00);
        do_read(4'h0, v);
        check("R1 mask read", v, 8'hFF);
        do_read(4'h4, v);
        check("R1 request read", v, 8'hF0);
        do_read(4'h8, v);
        check("R1 mode read", v, 8'h03);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule